// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This execution unit works on two 64-bit operands that are treated as a row of equal-width integer lanes. A two-bit lane-size code picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Arithmetic and compare operations run on each lane on its own. No carry crosses a lane boundary, and the saturating forms clamp each lane separately instead of letting it wrap.

Bitwise operations ignore the lane size and act on all 64 bits. The two unpack operations interleave lanes taken from the lower or the upper halves of the two sources. Lane 0 always sits at the least significant end of the word.

A caller presents the operands, a 4-bit opcode and the lane size together with `in_valid`. The result and `out_valid` come from registers and appear on the next clock edge. While `in_valid` is low, the registered result keeps its value.

Top module: `simd_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the `in_valid` sampled at the previous rising edge. When `in_valid` is low, `result` keeps its value.
- R3: Opcode 0 (wrapping add) returns, for each lane, (A lane + B lane) modulo 2^W, where W is the lane width. Lane size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Lane i occupies bits [i*W+W-1 : i*W].
- R4: Opcode 1 (signed saturating add) returns the two's-complement lane sum. A sum above the lane maximum gives 2^(W-1)-1, and a sum below the lane minimum gives -2^(W-1).
- R5: Opcode 2 (unsigned saturating add) returns the unsigned lane sum, or all ones when that sum exceeds 2^W-1. For example, 16-bit 0xF000 + 0x3000 gives 0xFFFF.
- R6: Opcode 3 (compare equal) sets a lane to all ones when the A and B lanes are equal, and to all zeros otherwise.
- R7: Opcode 4 (compare greater) sets a lane to all ones when the A lane is greater than the B lane as a signed two's-complement value, and to all zeros otherwise.
- R8: Opcodes 5 to 8 give A AND B, (NOT A) AND B, A OR B and A XOR B over all 64 bits, whatever the lane size.
- R9: Opcode 9 (unpack low) uses the lower-half lanes. For each i below half the lane count, output lane 2i is A lane i and output lane 2i+1 is B lane i. With a 64-bit lane, the result is A.
- R10: Opcode 10 (unpack high) uses the upper-half lanes. Output lane 2j is A lane (N/2+j) and output lane 2j+1 is B lane (N/2+j), where N is the lane count. With a 64-bit lane, the result is B.
- R11: Opcodes 11 to 15 give a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op_a | input | 64 | Source A |
| op_b | input | 64 | Source B |
| opcode | input | 4 | Operation select (see R3 to R11) |
| lane_sz | input | 2 | Lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered packed result |

## Verification
The lane-level assertions assume that both operands carry known values whenever they are evaluated, so each check is guarded against unknown bits. The bench never leaves the operands undriven after time zero. The temporal checks assume that `in_valid` is low during and right after reset; the stimulus holds it low until the first vector. The sweep drives every opcode, including the unused codes, at every lane size. Each combination gets exhaustive pairs of lane-boundary patterns plus pseudo-random words. These inputs keep every encoding inside the ranges the requirements define.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int unsigned VEC_W  = 64;
  localparam int unsigned NUM_SZ = 4;
  localparam int unsigned BASE_W = 8;

  typedef enum logic [3:0] {
    OP_ADD_WRAP = 4'd0,
    OP_ADD_SSAT = 4'd1,
    OP_ADD_USAT = 4'd2,
    OP_CMP_EQ   = 4'd3,
    OP_CMP_GT   = 4'd4,
    OP_AND      = 4'd5,
    OP_ANDN     = 4'd6,
    OP_OR       = 4'd7,
    OP_XOR      = 4'd8,
    OP_UNP_LO   = 4'd9,
    OP_UNP_HI   = 4'd10
  } simd_op_e;

  typedef struct packed {
    logic [VEC_W-1:0] add_wrap;
    logic [VEC_W-1:0] add_ssat;
    logic [VEC_W-1:0] add_usat;
    logic [VEC_W-1:0] cmp_eq;
    logic [VEC_W-1:0] cmp_gt;
    logic [VEC_W-1:0] unp_lo;
    logic [VEC_W-1:0] unp_hi;
  } size_res_t;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_alu_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] add_wrap,
  output logic [VEC_W-1:0] add_ssat,
  output logic [VEC_W-1:0] add_usat,
  output logic [VEC_W-1:0] cmp_eq,
  output logic [VEC_W-1:0] cmp_gt
);
  localparam int unsigned LANES = VEC_W / LANE_W;
  localparam int unsigned MSB   = LANE_W - 1;
  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb, wr;
    logic [LANE_W:0]   sum;
    logic              ovf;

    assign la  = a[i*LANE_W +: LANE_W];
    assign lb  = b[i*LANE_W +: LANE_W];
    assign sum = {1'b0, la} + {1'b0, lb};
    assign wr  = sum[LANE_W-1:0];
    assign ovf = (la[MSB] == lb[MSB]) && (wr[MSB] != la[MSB]);

    assign add_wrap[i*LANE_W +: LANE_W] = wr;
    assign add_ssat[i*LANE_W +: LANE_W] = ovf ? (la[MSB] ? S_MIN : S_MAX) : wr;
    assign add_usat[i*LANE_W +: LANE_W] = sum[LANE_W] ? {LANE_W{1'b1}} : wr;
    assign cmp_eq[i*LANE_W +: LANE_W]   = {LANE_W{la == lb}};
    assign cmp_gt[i*LANE_W +: LANE_W]   = {LANE_W{$signed(la) > $signed(lb)}};

    always_comb begin
      if (!$isunknown({la, lb})) begin
        // R5
        usat_floor_chk: assert (add_usat[i*LANE_W +: LANE_W] >= la &&
                                add_usat[i*LANE_W +: LANE_W] >= lb);
        // R4
        if (!la[MSB] && !lb[MSB])
          ssat_pos_chk: assert (!add_ssat[i*LANE_W + MSB]);
      end
    end
  end
endmodule

// File: rtl/simd_unpack.sv
module simd_unpack
  import simd_alu_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] lo,
  output logic [VEC_W-1:0] hi
);
  localparam int unsigned LANES = VEC_W / LANE_W;

  logic [2*VEC_W-1:0] mix;

  for (genvar i = 0; i < LANES; i++) begin : g_mix
    assign mix[(2*i)*LANE_W   +: LANE_W] = a[i*LANE_W +: LANE_W];
    assign mix[(2*i+1)*LANE_W +: LANE_W] = b[i*LANE_W +: LANE_W];
  end

  assign lo = mix[VEC_W-1:0];
  assign hi = mix[2*VEC_W-1:VEC_W];

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R9 R10: interleaving only moves bits, never creates or drops ones
      unpack_perm_chk: assert ($countones(lo) + $countones(hi) ==
                               $countones(a) + $countones(b));
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      op_a,
  input  logic [63:0]      op_b,
  input  logic [3:0]       opcode,
  input  logic [1:0]       lane_sz,
  output logic             out_valid,
  output logic [63:0]      result
);
  size_res_t        per_sz [NUM_SZ];
  size_res_t        sel;
  simd_op_e         op;
  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_q;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
    localparam int unsigned LW = BASE_W << k;

    simd_lane_arith #(.LANE_W(LW)) u_arith (
      .a        (op_a),
      .b        (op_b),
      .add_wrap (per_sz[k].add_wrap),
      .add_ssat (per_sz[k].add_ssat),
      .add_usat (per_sz[k].add_usat),
      .cmp_eq   (per_sz[k].cmp_eq),
      .cmp_gt   (per_sz[k].cmp_gt)
    );

    simd_unpack #(.LANE_W(LW)) u_unpack (
      .a  (op_a),
      .b  (op_b),
      .lo (per_sz[k].unp_lo),
      .hi (per_sz[k].unp_hi)
    );
  end

  // next-state logic
  always_comb begin
    sel = per_sz[lane_sz];
    op  = simd_op_e'(opcode);
    case (op)
      OP_ADD_WRAP: res_d = sel.add_wrap;
      OP_ADD_SSAT: res_d = sel.add_ssat;
      OP_ADD_USAT: res_d = sel.add_usat;
      OP_CMP_EQ:   res_d = sel.cmp_eq;
      OP_CMP_GT:   res_d = sel.cmp_gt;
      OP_AND:      res_d = op_a & op_b;
      OP_ANDN:     res_d = ~op_a & op_b;
      OP_OR:       res_d = op_a | op_b;
      OP_XOR:      res_d = op_a ^ op_b;
      OP_UNP_LO:   res_d = sel.unp_lo;
      OP_UNP_HI:   res_d = sel.unp_hi;
      default:     res_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R11
  unused_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > 4'd10) |=> (result == '0));
  // R8
  xor_lane_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd8) |=> (result == $past(op_a ^ op_b)));
endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_sz = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  simd_alu u_simd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane_sz(lane_sz), .out_valid(out_valid), .result(result)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5, 6, 7, 8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] model(input int op, input int sz,
                                        input logic [63:0] a, input logic [63:0] b);
    int w = 8 << sz;
    int n = 64 / w;
    logic [127:0] mix = '0;
    logic [63:0]  r = '0;
    case (op)
      5: return a & b;
      6: return ~a & b;
      7: return a | b;
      8: return a ^ b;
      default: ;
    endcase
    if (op > 10) return '0;
    for (int i = 0; i < n; i++) begin
      logic [64:0] ua = '0, ub = '0, us, lv;
      logic signed [65:0] sa, sb, ss, smax, smin;
      for (int j = 0; j < w; j++) begin
        ua[j] = a[i*w+j];
        ub[j] = b[i*w+j];
      end
      sa = $signed({1'b0, ua});
      sb = $signed({1'b0, ub});
      if (ua[w-1]) sa = sa - (66'sd1 << w);
      if (ub[w-1]) sb = sb - (66'sd1 << w);
      smax = (66'sd1 << (w-1)) - 66'sd1;
      smin = -(66'sd1 << (w-1));
      us = ua + ub;
      ss = sa + sb;
      lv = '0;
      case (op)
        0: lv = us;
        1: begin
          if (ss > smax) ss = smax;
          else if (ss < smin) ss = smin;
          lv = ss[64:0];
        end
        2: lv = (us >= (65'd1 << w)) ? {65{1'b1}} : us;
        3: lv = (ua == ub) ? {65{1'b1}} : '0;
        4: lv = (sa > sb) ? {65{1'b1}} : '0;
        default: ;
      endcase
      for (int j = 0; j < w; j++) begin
        r[i*w+j] = lv[j];
        mix[(2*i)*w+j]   = a[i*w+j];
        mix[(2*i+1)*w+j] = b[i*w+j];
      end
    end
    if (op == 9)  return mix[63:0];
    if (op == 10) return mix[127:64];
    return r;
  endfunction

  function automatic logic [63:0] corner(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h7F7F_7F7F_7F7F_7F7F;
      4: return 64'h0101_0101_0101_0101;
      5: return 64'hF000_F000_F000_F000;
      6: return 64'h3000_3000_3000_3000;
      default: return 64'h8000_0000_7FFF_FFFF;
    endcase
  endfunction

  task automatic apply(input int op, input int sz, input logic [63:0] a,
                       input logic [63:0] b);
    logic [63:0] exp;
    op_a = a; op_b = b; opcode = op[3:0]; lane_sz = sz[1:0]; in_valid = 1'b1;
    exp = model(op, sz, a, b);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b1 || result !== exp) begin
      bad++;
      $display("FAIL %s op=%0d sz=%0d a=%h b=%h: actual=%h/%b expected=%h/1",
               tag_of(op), op, sz, a, b, result, out_valid, exp);
    end
  endtask

  initial begin
    logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0) begin
      bad++;
      $display("FAIL R1 in reset: actual=%h/%b expected=0/0", result, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== '0) begin
      bad++;
      $display("FAIL R1 after release: actual=%h/%b expected=0/0", result, out_valid);
    end
    // R5 stated example: 16-bit 0xF000 + 0x3000 clamps to 0xFFFF
    apply(2, 1, 64'h0000_0000_0000_F000, 64'h0000_0000_0000_3000);
    total++;
    if (result[15:0] !== 16'hFFFF) begin
      bad++;
      $display("FAIL R5 example: actual=%h expected=ffff", result[15:0]);
    end
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 16; op++) begin
        for (int k = 0; k < 64; k++) apply(op, sz, corner(k % 8), corner(k / 8));
        for (int k = 0; k < 16; k++) begin
          logic [63:0] ra;
          x ^= x << 13; x ^= x >> 7; x ^= x << 17;
          ra = x;
          x ^= x << 13; x ^= x >> 7; x ^= x << 17;
          apply(op, sz, ra, (k % 4 == 0) ? ra : x);
        end
      end
    end
    // R2: idle cycle keeps result and drops valid
    held = result;
    in_valid = 1'b0; op_a = ~op_a; op_b = 64'h1234_5678_9ABC_DEF0; opcode = 4'd8;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== held) begin
      bad++;
      $display("FAIL R2 idle: actual=%h/%b expected=%h/0", result, out_valid, held);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule